// File: doc/BRIEF.md
# Nested Interrupt Level Arbiter

This block decides, every clock cycle, whether one of several pending peripheral interrupt requests may take over the processor from the code that is running now. Each request source has a two-bit level register that software writes. The block keeps a current-context register: a two-bit current level and an enable flag. A smaller level number means a more urgent request. The block picks the most urgent eligible request and accepts it only when interrupts are enabled and the request is strictly more urgent than the current level. A level of 3 is never taken. A current level of 0 shuts out every request.

On acceptance the block emits a one-cycle acknowledge with the winning source index. It pushes the old context onto a small internal save stack and loads the current level from the winner's level register. A return-from-interrupt strobe pops the stack and restores the context that was interrupted, so service routines can nest and each one resumes in turn. Software can also overwrite the context directly, for example to hold off further nesting while a routine runs.

Top module: `irq_nest_arb`

## Requirements
- R1: After reset the current level is 3, the enable flag is 0, the acknowledge and error outputs are low, and every source level register holds 3.
- R2: A source whose level register holds 3 or 0 is never accepted, whatever the current context.
- R3: A request is accepted only when its level is numerically smaller than the current level. A current level of 0 therefore blocks all requests.
- R4: While the enable flag is 0 no request is accepted.
- R5: Among eligible pending requests the smallest level wins. A tie goes to the lowest source index.
- R6: On acceptance `ack_o` is high for one cycle, starting one clock edge after the request was sampled. `ack_idx_o` carries the winner, `cur_il_o` then shows the winner's level, and the enable flag keeps its value.
- R7: A more urgent request that arrives while a less urgent one is being served is accepted, and the context nests.
- R8: A return strobe restores the level and enable flag that were current just before the most recent acceptance that has not yet been unwound.
- R9: A return strobe with an empty save stack changes nothing and makes `stk_err_o` high for exactly the next cycle.
- R10: While the save stack holds DEPTH (default 3) entries no request is accepted. After a pop, acceptance is possible again.
- R11: Within one cycle a return strobe beats a context write, and a context write beats acceptance. A context write loads `ctx_il_i` and `ctx_ie_i` at the next edge, and no acknowledge comes from that cycle.
- R12: A level register write takes effect for comparisons from the cycle after the write. A request in the same cycle is judged against the old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_i | input | N_SRC | Pending request of each source |
| lvl_we_i | input | 1 | Write strobe for one source level register |
| lvl_idx_i | input | IDX_W | Source whose level register is written |
| lvl_val_i | input | 2 | New level value |
| ctx_we_i | input | 1 | Write strobe for the current context |
| ctx_il_i | input | 2 | Level value written to the context |
| ctx_ie_i | input | 1 | Enable value written to the context |
| reti_i | input | 1 | Return-from-interrupt strobe |
| ack_o | output | 1 | One-cycle acknowledge of an accepted request |
| ack_idx_o | output | IDX_W | Index of the accepted source, valid with ack_o |
| cur_il_o | output | 2 | Current level |
| cur_ie_o | output | 1 | Current enable flag |
| stk_err_o | output | 1 | One-cycle pulse after a return strobe with an empty stack |

## Verification
Every result is due exactly one clock edge after its cause. The acknowledge, the winner index and the new current level follow the edge that samples the request. The restored context follows the edge that samples the return strobe. The error pulse follows the ignored return and falls one edge later. A level write is seen by the request sampled one edge later. The bench changes inputs on the falling edge, crosses one rising edge, and reads the outputs on the next falling edge. In this way each check lands in the cycle its requirement names. Directed sequences probe the pulse width and same-cycle conflicts, and check that the level in use is the old one during a level write.

// File: rtl/irq_nest_pkg.sv
package irq_nest_pkg;
  parameter int LVL_W = 2;

  typedef logic [LVL_W-1:0] lvl_t;

  // level code that masks every request when held as the current level
  localparam lvl_t LVL_MASK_ALL = '0;
  // level code that is never granted
  localparam lvl_t LVL_NEVER = '1;

  typedef struct packed {
    logic ie;
    lvl_t il;
  } ctx_t;

  function automatic logic lvl_usable(input lvl_t l);
    return (l != LVL_MASK_ALL) && (l != LVL_NEVER);
  endfunction
endpackage

// File: rtl/irq_lvl_regs.sv
module irq_lvl_regs
  import irq_nest_pkg::*;
#(
  parameter int N_SRC = 4,
  parameter int IDX_W = 2
) (
  input  logic                         clk,
  input  logic                         rst_l,
  input  logic                         wr_en,
  input  logic [IDX_W-1:0]             wr_idx,
  input  lvl_t                         wr_lvl,
  output logic [N_SRC-1:0][LVL_W-1:0]  lvl_o
);

  for (genvar g = 0; g < N_SRC; g++) begin : g_src
    lvl_t lvl_q;
    lvl_t lvl_d;
    logic lvl_en;

    // clock enable for this source's register
    always_comb begin
      lvl_en = wr_en && (wr_idx == IDX_W'(g));
      lvl_d  = wr_lvl;
    end

    always_ff @(posedge clk or negedge rst_l) begin
      if (!rst_l) begin
        lvl_q <= LVL_NEVER;
      end else if (lvl_en) begin
        lvl_q <= lvl_d;
      end
    end

    assign lvl_o[g] = lvl_q;
  end

endmodule

// File: rtl/irq_pick.sv
module irq_pick
  import irq_nest_pkg::*;
#(
  parameter int N_SRC = 4,
  parameter int IDX_W = 2
) (
  input  logic [N_SRC-1:0]             req,
  input  logic [N_SRC-1:0][LVL_W-1:0]  lvl,
  output logic                         found,
  output lvl_t                         best_lvl,
  output logic [IDX_W-1:0]             best_idx
);

  logic [N_SRC-1:0] elig;

  for (genvar g = 0; g < N_SRC; g++) begin : g_elig
    assign elig[g] = req[g] && lvl_usable(lvl[g]);
  end

  // linear scan: strict compare keeps the lowest index on a tie
  always_comb begin
    found    = 1'b0;
    best_lvl = LVL_NEVER;
    best_idx = '0;
    for (int i = 0; i < N_SRC; i++) begin
      if (elig[i] && (lvl[i] < best_lvl)) begin
        found    = 1'b1;
        best_lvl = lvl[i];
        best_idx = IDX_W'(i);
      end
    end
  end

endmodule

// File: rtl/irq_save_stack.sv
module irq_save_stack
  import irq_nest_pkg::*;
#(
  parameter int DEPTH = 3,
  localparam int PTR_W = $clog2(DEPTH + 1)
) (
  input  logic clk,
  input  logic rst_l,
  input  logic push,
  input  logic pop,
  input  ctx_t push_data,
  output ctx_t top,
  output logic empty,
  output logic full
);

  logic [PTR_W-1:0] cnt_q;
  logic [PTR_W-1:0] cnt_d;
  logic             cnt_en;
  ctx_t             slot [DEPTH];

  assign empty = (cnt_q == '0);
  assign full  = (cnt_q == PTR_W'(DEPTH));

  always_comb begin
    cnt_en = (push && !full) || (pop && !empty);
    cnt_d  = cnt_q;
    if (push && !full) begin
      cnt_d = cnt_q + 1'b1;
    end else if (pop && !empty) begin
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_l) begin
    if (!rst_l) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    ctx_t q;
    logic we;

    assign we = push && !full && (cnt_q == PTR_W'(g));

    always_ff @(posedge clk or negedge rst_l) begin
      if (!rst_l) begin
        q <= '0;
      end else if (we) begin
        q <= push_data;
      end
    end

    assign slot[g] = q;
  end

  // most recently pushed entry
  always_comb begin
    top = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (cnt_q == PTR_W'(i + 1)) begin
        top = slot[i];
      end
    end
  end

endmodule

// File: rtl/irq_nest_arb.sv
module irq_nest_arb
  import irq_nest_pkg::*;
#(
  parameter int N_SRC = 4,
  parameter int DEPTH = 3,
  localparam int IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] req_i,
  input  logic             lvl_we_i,
  input  logic [IDX_W-1:0] lvl_idx_i,
  input  logic [1:0]       lvl_val_i,
  input  logic             ctx_we_i,
  input  logic [1:0]       ctx_il_i,
  input  logic             ctx_ie_i,
  input  logic             reti_i,
  output logic             ack_o,
  output logic [IDX_W-1:0] ack_idx_o,
  output logic [1:0]       cur_il_o,
  output logic             cur_ie_o,
  output logic             stk_err_o
);

  // reset: asserted at once, released on a clock edge
  logic rst_meta;
  logic rst_l;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_l    <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_l    <= rst_meta;
    end
  end

  logic [N_SRC-1:0][LVL_W-1:0] lvl;
  logic                        found;
  lvl_t                        best_lvl;
  logic [IDX_W-1:0]            best_idx;
  ctx_t                        ctx_q;
  ctx_t                        ctx_d;
  logic                        ctx_en;
  ctx_t                        stk_top;
  logic                        stk_empty;
  logic                        stk_full;
  logic                        push;
  logic                        pop;
  logic                        grant;
  logic                        ack_d;
  logic                        err_d;
  logic [IDX_W-1:0]            idx_q;

  irq_lvl_regs #(
    .N_SRC (N_SRC),
    .IDX_W (IDX_W)
  ) u_lvl (
    .clk    (clk),
    .rst_l  (rst_l),
    .wr_en  (lvl_we_i),
    .wr_idx (lvl_idx_i),
    .wr_lvl (lvl_val_i),
    .lvl_o  (lvl)
  );

  irq_pick #(
    .N_SRC (N_SRC),
    .IDX_W (IDX_W)
  ) u_pick (
    .req      (req_i),
    .lvl      (lvl),
    .found    (found),
    .best_lvl (best_lvl),
    .best_idx (best_idx)
  );

  irq_save_stack #(
    .DEPTH (DEPTH)
  ) u_stk (
    .clk       (clk),
    .rst_l     (rst_l),
    .push      (push),
    .pop       (pop),
    .push_data (ctx_q),
    .top       (stk_top),
    .empty     (stk_empty),
    .full      (stk_full)
  );

  // acceptance test against the live context
  assign grant = found && ctx_q.ie && (best_lvl < ctx_q.il) && !stk_full;

  // next-state: return beats context write beats acceptance
  always_comb begin
    ctx_d  = ctx_q;
    ctx_en = 1'b0;
    push   = 1'b0;
    pop    = 1'b0;
    ack_d  = 1'b0;
    err_d  = 1'b0;
    if (reti_i) begin
      if (!stk_empty) begin
        pop    = 1'b1;
        ctx_d  = stk_top;
        ctx_en = 1'b1;
      end else begin
        err_d = 1'b1;
      end
    end else if (ctx_we_i) begin
      ctx_d.il = ctx_il_i;
      ctx_d.ie = ctx_ie_i;
      ctx_en   = 1'b1;
    end else if (grant) begin
      push     = 1'b1;
      ctx_d.il = best_lvl;
      ctx_en   = 1'b1;
      ack_d    = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_l) begin
    if (!rst_l) begin
      ctx_q.il <= LVL_NEVER;
      ctx_q.ie <= 1'b0;
    end else if (ctx_en) begin
      ctx_q <= ctx_d;
    end
  end

  always_ff @(posedge clk or negedge rst_l) begin
    if (!rst_l) begin
      ack_o     <= 1'b0;
      stk_err_o <= 1'b0;
    end else begin
      ack_o     <= ack_d;
      stk_err_o <= err_d;
    end
  end

  always_ff @(posedge clk or negedge rst_l) begin
    if (!rst_l) begin
      idx_q <= '0;
    end else if (ack_d) begin
      idx_q <= best_idx;
    end
  end

  assign ack_idx_o = idx_q;
  assign cur_il_o  = ctx_q.il;
  assign cur_ie_o  = ctx_q.ie;

endmodule

// File: rtl/irq_nest_arb_chk.sv
module irq_nest_arb_chk #(
  parameter int N_SRC = 4,
  parameter int IDX_W = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic [N_SRC-1:0] req_i,
  input logic             ctx_we_i,
  input logic             reti_i,
  input logic             ack_o,
  input logic [IDX_W-1:0] ack_idx_o,
  input logic [1:0]       cur_il_o,
  input logic             cur_ie_o,
  input logic             stk_err_o
);

  logic [N_SRC-1:0] req_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q <= '0;
    end else begin
      req_q <= req_i;
    end
  end

  // R2: the level now in force after a grant is never 0 or 3
  a_r2_granted_level_usable: assert property (@(posedge clk) disable iff (!rst_n)
    ack_o |-> (cur_il_o != 2'd0) && (cur_il_o != 2'd3));

  // R3: a grant always moves to a strictly more urgent level
  a_r3_strictly_more_urgent: assert property (@(posedge clk) disable iff (!rst_n)
    ack_o |-> (cur_il_o < $past(cur_il_o)));

  // R4: a grant needs the enable flag set in the sampling cycle
  a_r4_enable_needed: assert property (@(posedge clk) disable iff (!rst_n)
    ack_o |-> $past(cur_ie_o));

  // R5: the granted source had its request raised
  a_r5_winner_was_pending: assert property (@(posedge clk) disable iff (!rst_n)
    ack_o |-> req_q[ack_idx_o]);

  // R6: a grant leaves the enable flag as it was
  a_r6_enable_kept: assert property (@(posedge clk) disable iff (!rst_n)
    ack_o |-> (cur_ie_o == $past(cur_ie_o)));

  // R9: an ignored return leaves the context untouched
  a_r9_err_no_change: assert property (@(posedge clk) disable iff (!rst_n)
    stk_err_o |-> $stable(cur_il_o) && $stable(cur_ie_o));

  // R11: no grant from a cycle holding a return or a context write
  a_r11_ctl_blocks_grant: assert property (@(posedge clk) disable iff (!rst_n)
    ack_o |-> !$past(reti_i) && !$past(ctx_we_i));

endmodule

bind irq_nest_arb irq_nest_arb_chk #(
  .N_SRC (N_SRC),
  .IDX_W (IDX_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_i     (req_i),
  .ctx_we_i  (ctx_we_i),
  .reti_i    (reti_i),
  .ack_o     (ack_o),
  .ack_idx_o (ack_idx_o),
  .cur_il_o  (cur_il_o),
  .cur_ie_o  (cur_ie_o),
  .stk_err_o (stk_err_o)
);

// File: tb/irq_nest_arb_test.sv
module irq_nest_arb_test;
  localparam int N = 4;
  localparam int IW = 2;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [N-1:0]  req_i;
  logic          lvl_we_i;
  logic [IW-1:0] lvl_idx_i;
  logic [1:0]    lvl_val_i;
  logic          ctx_we_i;
  logic [1:0]    ctx_il_i;
  logic          ctx_ie_i;
  logic          reti_i;
  logic          ack_o;
  logic [IW-1:0] ack_idx_o;
  logic [1:0]    cur_il_o;
  logic          cur_ie_o;
  logic          stk_err_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  irq_nest_arb #(.N_SRC(N), .DEPTH(3)) uut (
    .clk(clk), .rst_n(rst_n), .req_i(req_i),
    .lvl_we_i(lvl_we_i), .lvl_idx_i(lvl_idx_i), .lvl_val_i(lvl_val_i),
    .ctx_we_i(ctx_we_i), .ctx_il_i(ctx_il_i), .ctx_ie_i(ctx_ie_i),
    .reti_i(reti_i), .ack_o(ack_o), .ack_idx_o(ack_idx_o),
    .cur_il_o(cur_il_o), .cur_ie_o(cur_ie_o), .stk_err_o(stk_err_o)
  );

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic idle();
    req_i = '0; lvl_we_i = 0; lvl_idx_i = '0; lvl_val_i = '0;
    ctx_we_i = 0; ctx_il_i = '0; ctx_ie_i = 0; reti_i = 0;
  endtask

  task automatic set_lvl(input int idx, input int v);
    lvl_we_i = 1; lvl_idx_i = IW'(idx); lvl_val_i = 2'(v);
    tick();
    lvl_we_i = 0;
  endtask

  task automatic set_ctx(input int il, input bit ie);
    ctx_we_i = 1; ctx_il_i = 2'(il); ctx_ie_i = ie;
    tick();
    ctx_we_i = 0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

  initial begin
    int lv[N];
    int best, bidx;
    bit exp_acc;
    idle();
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) tick();

    // R1: reset state
    chk(cur_il_o == 2'd3, "R1 level", cur_il_o, 3);
    chk(cur_ie_o == 1'b0, "R1 enable", cur_ie_o, 0);
    chk(ack_o == 1'b0, "R1 ack", ack_o, 0);
    chk(stk_err_o == 1'b0, "R1 err", stk_err_o, 0);
    // R1: levels reset to 3 -> nothing taken even when enabled
    set_ctx(3, 1);
    req_i = '1;
    tick();
    chk(ack_o == 1'b0, "R1 level regs at 3", ack_o, 0);
    req_i = '0;

    // R2 R3 R4 R5 R6 R8: sweep of all level setups, requests and levels
    for (int c = 0; c < 256; c++) begin
      for (int i = 0; i < N; i++) begin
        lv[i] = (c >> (2 * i)) & 3;
        set_lvl(i, lv[i]);
      end
      // R4: enable cleared blocks everything
      set_ctx(3, 0);
      req_i = '1;
      tick();
      chk(ack_o == 1'b0, "R4 enable off", ack_o, 0);
      req_i = '0;
      for (int r = 0; r < 16; r++) begin
        for (int il = 0; il < 4; il++) begin
          best = 3; bidx = 0;
          for (int i = 0; i < N; i++) begin
            if (r[i] && lv[i] != 0 && lv[i] != 3 && lv[i] < best) begin
              best = lv[i]; bidx = i;
            end
          end
          exp_acc = (best < 3) && (best < il);
          set_ctx(il, 1);
          req_i = N'(r);
          tick();
          chk(ack_o == exp_acc, "R3 R2 grant", ack_o, exp_acc);
          if (exp_acc) begin
            chk(ack_idx_o == IW'(bidx), "R5 winner", ack_idx_o, bidx);
            chk(cur_il_o == 2'(best), "R6 new level", cur_il_o, best);
            chk(cur_ie_o == 1'b1, "R6 enable kept", cur_ie_o, 1);
          end else begin
            chk(cur_il_o == 2'(il), "R3 level unchanged", cur_il_o, il);
          end
          req_i = '0;
          reti_i = exp_acc;
          tick();
          reti_i = 0;
          chk(ack_o == 1'b0, "R6 single pulse", ack_o, 0);
          if (exp_acc) chk(cur_il_o == 2'(il), "R8 restore", cur_il_o, il);
        end
      end
    end

    // R7 R8: nesting, with enable cleared inside the inner routine
    set_lvl(0, 3); set_lvl(1, 2); set_lvl(2, 1); set_lvl(3, 3);
    set_ctx(3, 1);
    req_i = 4'b0010;
    tick();
    chk(ack_o && ack_idx_o == 2'd1, "R7 outer grant", ack_idx_o, 1);
    req_i = 4'b0110;
    tick();
    chk(ack_o && ack_idx_o == 2'd2, "R7 preempt", ack_idx_o, 2);
    chk(cur_il_o == 2'd1, "R7 nested level", cur_il_o, 1);
    req_i = '0;
    set_ctx(1, 0);
    reti_i = 1;
    tick();
    chk(cur_il_o == 2'd2, "R8 inner return level", cur_il_o, 2);
    chk(cur_ie_o == 1'b1, "R8 inner return enable", cur_ie_o, 1);
    tick();
    reti_i = 0;
    chk(cur_il_o == 2'd3, "R8 outer return level", cur_il_o, 3);

    // R9: return with empty stack
    reti_i = 1;
    tick();
    reti_i = 0;
    chk(stk_err_o == 1'b1, "R9 err pulse", stk_err_o, 1);
    chk(cur_il_o == 2'd3 && cur_ie_o, "R9 context kept", cur_il_o, 3);
    tick();
    chk(stk_err_o == 1'b0, "R9 err one cycle", stk_err_o, 0);

    // R10: stack full blocks grants
    for (int k = 0; k < 3; k++) begin
      set_ctx(3, 1);
      req_i = 4'b0010;
      tick();
      chk(ack_o == 1'b1, "R10 fill grant", ack_o, 1);
      req_i = '0;
    end
    set_ctx(3, 1);
    req_i = 4'b0010;
    tick();
    chk(ack_o == 1'b0, "R10 full blocks", ack_o, 0);
    req_i = '0;
    reti_i = 1;
    tick();
    reti_i = 0;
    chk(cur_il_o == 2'd3, "R10 pop level", cur_il_o, 3);
    req_i = 4'b0010;
    tick();
    chk(ack_o == 1'b1, "R10 grant after pop", ack_o, 1);
    req_i = '0;
    reti_i = 1;
    repeat (3) tick();
    reti_i = 0;
    chk(stk_err_o == 1'b0 && cur_il_o == 2'd3, "R10 drained", cur_il_o, 3);

    // R11: return beats context write
    req_i = 4'b0010;
    tick();
    req_i = '0;
    reti_i = 1; ctx_we_i = 1; ctx_il_i = 2'd0; ctx_ie_i = 0;
    tick();
    reti_i = 0; ctx_we_i = 0;
    chk(cur_il_o == 2'd3 && cur_ie_o, "R11 return wins", cur_il_o, 3);
    // R11: context write beats grant
    ctx_we_i = 1; ctx_il_i = 2'd3; ctx_ie_i = 1; req_i = 4'b0100;
    tick();
    ctx_we_i = 0;
    chk(ack_o == 1'b0, "R11 write blocks grant", ack_o, 0);
    tick();
    chk(ack_o == 1'b1 && ack_idx_o == 2'd2, "R11 grant next cycle", ack_idx_o, 2);
    req_i = '0;
    reti_i = 1;
    tick();
    reti_i = 0;

    // R12: level write seen one cycle later
    set_ctx(2, 1);
    lvl_we_i = 1; lvl_idx_i = 2'd3; lvl_val_i = 2'd1; req_i = 4'b1000;
    tick();
    lvl_we_i = 0;
    chk(ack_o == 1'b0, "R12 old level used", ack_o, 0);
    tick();
    chk(ack_o == 1'b1 && ack_idx_o == 2'd3, "R12 new level used", ack_idx_o, 3);
    req_i = '0;
    reti_i = 1;
    tick();
    reti_i = 0;
    chk(cur_il_o == 2'd2, "R12 restore", cur_il_o, 2);

    finish_run();
  end
endmodule